// File: doc/BRIEF.md
# I2C Event Interrupt Flag Unit

This block watches the SCL and SDA lines of an I2C peripheral and turns bus events into sticky interrupt flags. It synchronises both lines, recognises start, repeated-start and stop conditions, and counts SCL falling edges inside each byte. At fixed edge numbers it raises flags for an address byte, a received data byte, the acknowledge slot and the end of a byte count. It also tracks a receive-buffer-full status and a receive interrupt flag, and it can request clock stretching at the acknowledge slot.

Address matching, data shifting and host sequencing stay outside the block. Three level inputs stand in for them: a client-addressed indication, a host-write direction and a byte-count-zero indication. Software reaches the block through write-one-to-clear strobes, an enable-mask write port, a global interrupt enable, hold enables, a receive-buffer read strobe, a clear-buffer strobe and a stretch release strobe.

Top module: `i2c_evt_irq`

## Requirements
- R1: After reset, `flags_o`, `rxbf_o`, `rxif_o`, `stretch_o`, `gen_if_o` and `irq_o` are all 0 and `pie_o` is 0.
- R2: Flag bit 0 sets on a start (SDA falls while SCL is high and the bus is idle). Flag bit 1 sets on a restart (the same pattern while a transfer is active). Flag bit 2 sets on a stop (SDA rises while SCL is high).
- R3: The falling-edge count restarts on start, restart or stop. The first SCL fall after a start or restart is not counted. Counting runs from 1 to 9 and then wraps to 1 for the next byte.
- R4: Flag bit 6 sets on the 9th counted falling edge while `cnt_zero_i` is high.
- R5: Flag bit 5 sets on the 9th counted falling edge while `client_addr_i` is high. If `ack_hold_en_i` is high and SDA was low at the preceding SCL rise (ACK), `stretch_o` sets. On a NACK it does not set.
- R6: Once set, `stretch_o` stays high until a `stretch_rel_i` pulse.
- R7: On the 8th counted falling edge of any byte other than the first after a start or restart, while `client_addr_i` and `host_wr_i` are high, flag bit 4, `rxbf_o` and `rxif_o` all set.
- R8: Hardware never clears flag bit 4, and only software clears it. `rxbf_o` and `rxif_o` ignore the flag clear strobes and clear only on `rxb_rd_i` or `clrbf_i`.
- R9: Flag bit 3 sets on the 9th counted falling edge of the first byte after a start or restart while `client_addr_i` is high.
- R10: `gen_if_o` is high whenever a set flag has its bit set in `pie_o`, or when `rxif_o` and `wr_hold_en_i` are both high.
- R11: Flags set whatever the value of `gie_i`. `irq_o` pulses for one cycle when an enabled flag newly sets, and only while `gie_i` is high.
- R12: A `flag_clr_i` pulse clears exactly the flag bits written with 1. A hardware set in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line |
| cnt_zero_i | input | 1 | Byte counter has reached zero |
| client_addr_i | input | 1 | Device is addressed as a client |
| host_wr_i | input | 1 | Host is writing data to this client |
| flag_clr_i | input | 7 | Write-one-to-clear strobe for the event flags |
| pie_we_i | input | 1 | Enable mask write strobe |
| pie_wdata_i | input | 7 | Enable mask write data |
| gie_i | input | 1 | Global interrupt enable |
| ack_hold_en_i | input | 1 | Acknowledge hold enable |
| wr_hold_en_i | input | 1 | Data-write hold enable |
| rxb_rd_i | input | 1 | Receive buffer read strobe |
| clrbf_i | input | 1 | Clear-buffer command strobe |
| stretch_rel_i | input | 1 | Clock-stretch release strobe |
| flags_o | output | 7 | Event flags |
| pie_o | output | 7 | Enable mask |
| rxbf_o | output | 1 | Receive buffer full status |
| rxif_o | output | 1 | Receive interrupt flag |
| gen_if_o | output | 1 | Generic interrupt flag |
| irq_o | output | 1 | Interrupt event pulse |
| stretch_o | output | 1 | Clock-stretch request |

## Verification
The bench builds the block with its defaults: two synchroniser stages and nine edges per byte. With nine edges the 8th-edge data flag and the 9th-edge acknowledge flags are reachable as separate observation points, and two bytes in a row exercise the wrap of the counter. Holding each bus phase for four clocks lets every synchroniser and edge detector settle before the next transition, so start, restart and stop fall apart cleanly. A restart in the middle of a byte shows that the counter restarts and that the first byte after a restart again counts as an address byte.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int NFLAG      = 7;
  localparam int FL_START   = 0;
  localparam int FL_RESTART = 1;
  localparam int FL_STOP    = 2;
  localparam int FL_ADDR    = 3;
  localparam int FL_WR      = 4;
  localparam int FL_ACK     = 5;
  localparam int FL_CNT     = 6;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/i2c_bus_detect.sv
module i2c_bus_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_o,
  output logic start_o,
  output logic restart_o,
  output logic stop_o,
  output logic busy_o
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_s, sda_s, scl_q, sda_q, busy_q, hi_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign sda_s = sda_sh[SYNC_STAGES-1];

  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign sda_o      = sda_s;
  assign hi_fall    = scl_s & scl_q & sda_q & ~sda_s;
  assign start_o    = hi_fall & ~busy_q;
  assign restart_o  = hi_fall & busy_q;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
  assign busy_o     = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= 1'b0;
    else if (start_o) busy_q <= 1'b1;
    else if (stop_o)  busy_q <= 1'b0;
  end

  p_busy_after_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> busy_o);
  p_idle_after_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !busy_o);
endmodule

// File: rtl/i2c_edge_count.sv
module i2c_edge_count #(
  parameter int BYTE_EDGES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_rise_i,
  input  logic scl_fall_i,
  input  logic sda_i,
  input  logic start_i,
  input  logic restart_i,
  input  logic stop_i,
  output logic data_fall_o,
  output logic ack_fall_o,
  output logic first_byte_o,
  output logic ack_low_o
);
  localparam int CW = $clog2(BYTE_EDGES + 1);
  localparam logic [CW-1:0] LAST = CW'(BYTE_EDGES);
  localparam logic [CW-1:0] DATA = CW'(BYTE_EDGES - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic skip_q, first_q, sda_at_rise_q, counted, sync_clr;

  assign sync_clr = start_i | restart_i | stop_i;
  assign counted  = scl_fall_i & ~skip_q & ~sync_clr;
  assign cnt_nxt  = (cnt_q == LAST) ? CW'(1) : cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      skip_q <= 1'b1;
    end else if (sync_clr) begin
      cnt_q  <= '0;
      skip_q <= 1'b1;
    end else if (scl_fall_i) begin
      if (skip_q) skip_q <= 1'b0;
      else        cnt_q  <= cnt_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      first_q <= 1'b0;
    else if (start_i || restart_i)    first_q <= 1'b1;
    else if (stop_i || ack_fall_o)    first_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sda_at_rise_q <= 1'b1;
    else if (scl_rise_i) sda_at_rise_q <= sda_i;
  end

  assign data_fall_o  = counted & (cnt_nxt == DATA);
  assign ack_fall_o   = counted & (cnt_nxt == LAST);
  assign first_byte_o = first_q;
  assign ack_low_o    = ~sda_at_rise_q;

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_ack_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fall_o |=> cnt_q == LAST);
  p_restart_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || restart_i) |=> (cnt_q == '0) && first_byte_o);
endmodule

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank
  import i2c_evt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  flag_vec_t set_i,
  input  flag_vec_t flag_clr_i,
  input  logic      pie_we_i,
  input  flag_vec_t pie_wdata_i,
  input  logic      gie_i,
  input  logic      ack_hold_en_i,
  input  logic      wr_hold_en_i,
  input  logic      ack_low_i,
  input  logic      rxb_rd_i,
  input  logic      clrbf_i,
  input  logic      stretch_rel_i,
  output flag_vec_t flags_o,
  output flag_vec_t pie_o,
  output logic      rxbf_o,
  output logic      rxif_o,
  output logic      gen_if_o,
  output logic      irq_o,
  output logic      stretch_o
);
  flag_vec_t flags_q, pie_q;
  logic rxbf_q, rxif_q, irq_q, stretch_q, rx_set, new_evt;

  assign rx_set  = set_i[FL_WR];
  // an event counts only on the transition of a flag from clear to set
  assign new_evt = (|(set_i & ~flags_q & pie_q)) | (rx_set & ~rxif_q & wr_hold_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      pie_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~flag_clr_i) | set_i;
      if (pie_we_i) pie_q <= pie_wdata_i;
      irq_q <= gie_i & new_evt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxbf_q <= 1'b0;
      rxif_q <= 1'b0;
    end else if (rx_set) begin
      rxbf_q <= 1'b1;
      rxif_q <= 1'b1;
    end else if (rxb_rd_i || clrbf_i) begin
      rxbf_q <= 1'b0;
      rxif_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      stretch_q <= 1'b0;
    else if (set_i[FL_ACK] && ack_hold_en_i && ack_low_i) stretch_q <= 1'b1;
    else if (stretch_rel_i)                           stretch_q <= 1'b0;
  end

  assign flags_o   = flags_q;
  assign pie_o     = pie_q;
  assign rxbf_o    = rxbf_q;
  assign rxif_o    = rxif_q;
  assign irq_o     = irq_q;
  assign stretch_o = stretch_q;
  assign gen_if_o  = (|(flags_q & pie_q)) | (rxif_q & wr_hold_en_i);

  for (genvar i = 0; i < NFLAG; i++) begin : g_sticky
    p_flag_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_q[i] && !flag_clr_i[i] |=> flags_q[i]);
  end

  p_irq_needs_gie_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(gie_i));
  p_stretch_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stretch_q && !stretch_rel_i |=> stretch_q);
  p_rx_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxbf_q && !rxb_rd_i && !clrbf_i |=> rxbf_q && rxif_q);
  p_rx_with_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_set |=> flags_q[FL_WR] && rxbf_q);
endmodule

// File: rtl/i2c_evt_irq.sv
module i2c_evt_irq
  import i2c_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_EDGES  = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             cnt_zero_i,
  input  logic             client_addr_i,
  input  logic             host_wr_i,
  input  logic [NFLAG-1:0] flag_clr_i,
  input  logic             pie_we_i,
  input  logic [NFLAG-1:0] pie_wdata_i,
  input  logic             gie_i,
  input  logic             ack_hold_en_i,
  input  logic             wr_hold_en_i,
  input  logic             rxb_rd_i,
  input  logic             clrbf_i,
  input  logic             stretch_rel_i,
  output logic [NFLAG-1:0] flags_o,
  output logic [NFLAG-1:0] pie_o,
  output logic             rxbf_o,
  output logic             rxif_o,
  output logic             gen_if_o,
  output logic             irq_o,
  output logic             stretch_o
);
  logic scl_rise, scl_fall, sda_s, start, restart, stop, busy;
  logic data_fall, ack_fall, first_byte, ack_low;
  flag_vec_t set_vec;

  i2c_bus_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .sda_o(sda_s),
    .start_o(start), .restart_o(restart), .stop_o(stop), .busy_o(busy)
  );

  i2c_edge_count #(.BYTE_EDGES(BYTE_EDGES)) u_count (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .start_i(start), .restart_i(restart), .stop_i(stop),
    .data_fall_o(data_fall), .ack_fall_o(ack_fall),
    .first_byte_o(first_byte), .ack_low_o(ack_low)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[FL_START]    = start;
    set_vec[FL_RESTART]  = restart;
    set_vec[FL_STOP]     = stop;
    set_vec[FL_ADDR]     = ack_fall & first_byte & client_addr_i;
    set_vec[FL_WR]       = data_fall & ~first_byte & client_addr_i & host_wr_i;
    set_vec[FL_ACK]      = ack_fall & client_addr_i;
    set_vec[FL_CNT]      = ack_fall & cnt_zero_i;
  end

  i2c_flag_bank u_bank (
    .clk_i, .rst_ni,
    .set_i(set_vec), .flag_clr_i, .pie_we_i, .pie_wdata_i, .gie_i,
    .ack_hold_en_i, .wr_hold_en_i, .ack_low_i(ack_low),
    .rxb_rd_i, .clrbf_i, .stretch_rel_i,
    .flags_o, .pie_o, .rxbf_o, .rxif_o, .gen_if_o, .irq_o, .stretch_o
  );

  p_restart_only_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FL_RESTART] && !$past(flags_o[FL_RESTART]) |-> $past(busy));
endmodule

// File: tb/test_i2c_evt_irq.sv
module test_i2c_evt_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic cnt_zero = 0, client = 0, host_wr = 0;
  logic [6:0] clr = '0, pie_wd = '0;
  logic pie_we = 0, gie = 0, ack_hold = 0, wr_hold = 0;
  logic rd = 0, clrbf = 0, rel = 0;
  logic [6:0] flags, pie;
  logic rxbf, rxif, gen_if, irq, stretch;
  int checks = 0, errors = 0, irq_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_evt_irq i_i2c_evt_irq (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .cnt_zero_i(cnt_zero), .client_addr_i(client), .host_wr_i(host_wr),
    .flag_clr_i(clr), .pie_we_i(pie_we), .pie_wdata_i(pie_wd), .gie_i(gie),
    .ack_hold_en_i(ack_hold), .wr_hold_en_i(wr_hold), .rxb_rd_i(rd),
    .clrbf_i(clrbf), .stretch_rel_i(rel),
    .flags_o(flags), .pie_o(pie), .rxbf_o(rxbf), .rxif_o(rxif),
    .gen_if_o(gen_if), .irq_o(irq), .stretch_o(stretch)
  );

  always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start;   sda = 0; tick(4); scl = 0; tick(4); endtask
  task automatic bus_restart; sda = 1; tick(4); scl = 1; tick(4); sda = 0; tick(4); scl = 0; tick(4); endtask
  task automatic bus_stop;    sda = 0; tick(4); scl = 1; tick(4); sda = 1; tick(4); endtask
  task automatic send_bit(input logic b); sda = b; tick(4); scl = 1; tick(4); scl = 0; tick(4); endtask
  task automatic send_bits(input int n); for (int i = 0; i < n; i++) send_bit(i[0]); endtask
  task automatic clr_flags(input logic [6:0] m); clr = m; tick(1); clr = '0; tick(1); endtask

  task automatic t_reset;
    chk("R1", "flags", flags, 0);   chk("R1", "pie", pie, 0);
    chk("R1", "rxbf", rxbf, 0);     chk("R1", "rxif", rxif, 0);
    chk("R1", "stretch", stretch, 0); chk("R1", "gen_if", gen_if, 0);
    chk("R1", "irq", irq, 0);
  endtask

  task automatic t_start_addr;
    client = 1; host_wr = 1;
    bus_start;
    chk("R2", "start flag", flags, 'h01);
    chk("R11", "no irq gie off", irq_cnt, 0);
    clr_flags('h7F);
    send_bits(8);
    chk("R9", "no addr/wr on 8th edge of first byte", flags, 'h00);
    send_bit(1'b0);
    chk("R9", "addr+ack after 9th edge", flags, 'h28);
    chk("R5", "no stretch hold off", stretch, 0);
  endtask

  task automatic t_data_ack;
    clr_flags('h7F);
    ack_hold = 1; wr_hold = 1; cnt_zero = 1;
    send_bits(8);
    chk("R7", "wr flag 8th edge", flags, 'h10);
    chk("R7", "rxbf", rxbf, 1);
    chk("R7", "rxif", rxif, 1);
    chk("R10", "gen_if via wr hold", gen_if, 1);
    send_bit(1'b0);
    chk("R4", "cnt+ack after 9th edge", flags, 'h70);
    chk("R5", "stretch on ack", stretch, 1);
  endtask

  task automatic t_rx_clear;
    clr_flags('h10);
    chk("R12", "only bit4 cleared", flags, 'h60);
    chk("R8", "rxbf ignores flag clear", rxbf, 1);
    rd = 1; tick(1); rd = 0; tick(1);
    chk("R8", "rxbf cleared by read", rxbf, 0);
    chk("R8", "rxif cleared by read", rxif, 0);
    chk("R6", "stretch held", stretch, 1);
    rel = 1; tick(1); rel = 0; tick(1);
    chk("R6", "stretch released", stretch, 0);
    clr_flags('h7F);
  endtask

  task automatic t_nack;
    cnt_zero = 0;
    send_bits(8);
    send_bit(1'b1);
    chk("R5", "ack flag on nack", flags, 'h30);
    chk("R5", "no stretch on nack", stretch, 0);
    clrbf = 1; tick(1); clrbf = 0; tick(1);
    chk("R8", "rxbf cleared by clrbf", rxbf, 0);
    chk("R8", "wr flag survives clrbf", flags[4], 1);
    clr_flags('h7F);
  endtask

  task automatic t_irq_stop;
    pie_wd = 'h04; pie_we = 1; tick(1); pie_we = 0; gie = 1; tick(1);
    chk("R11", "no irq before", irq_cnt, 0);
    chk("R10", "gen_if low", gen_if, 0);
    bus_stop;
    chk("R2", "stop flag", flags, 'h04);
    chk("R10", "gen_if enabled stop", gen_if, 1);
    chk("R11", "one irq pulse", irq_cnt, 1);
    gie = 0;
    clr_flags('h7F);
    chk("R10", "gen_if cleared", gen_if, 0);
  endtask

  task automatic t_restart;
    bus_start;
    clr_flags('h7F);
    send_bits(4);
    bus_restart;
    chk("R2", "restart flag", flags, 'h02);
    send_bits(8);
    chk("R3", "count restarted, no wr", flags, 'h02);
    send_bit(1'b0);
    chk("R3", "addr at 9th after restart", flags, 'h2A);
    chk("R5", "stretch after restart ack", stretch, 1);
    rel = 1; tick(1); rel = 0; tick(1);
    bus_stop;
    chk("R2", "stop after restart", flags, 'h2E);
    chk("R11", "no irq gie off", irq_cnt, 1);
    clr_flags('h08);
    chk("R12", "bit3 only", flags, 'h26);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    t_reset;
    t_start_addr;
    t_data_ack;
    t_rx_clear;
    t_nack;
    t_irq_stop;
    t_restart;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule